// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block adapts an external data port of 36, 18 or 9 bits to a storage path that always moves whole 36-bit words. On the write side it collects narrow beats into one full word and offers it toward storage. On the read side it takes full words from storage and hands them out as one, two or four narrow beats. Both sides use a valid/ready handshake, and a beat or word moves on a clock edge where valid and ready are both high.

Three select pins pick one of five width pairs, and a fourth pin picks whether the high or the low slice of a word moves first. All four pins are captured only while the master reset input is high, so the data paths see a fixed configuration between master resets. A partial reset empties both data paths but keeps the captured configuration. Either reset discards any word that is partly packed or partly unpacked.

Top module: `bus_width_adapter`

## Requirements
- R1: With `sel_match` low at master reset, both sides are 36 bits wide whatever `sel_in` and `sel_out` are, and words pass through unchanged in both directions.
- R2: With `sel_match` high, `sel_in` low and `sel_out` low, each 36-bit word from storage is delivered as two 18-bit read beats on `rd_data[17:0]`.
- R3: With `sel_match` high, `sel_in` low and `sel_out` high, each 36-bit word from storage is delivered as four 9-bit read beats on `rd_data[8:0]`.
- R4: With `sel_match` high, `sel_in` high and `sel_out` low, two 18-bit write beats taken from `wr_data[17:0]` form one 36-bit word, and `wr_data[35:18]` has no effect on it.
- R5: With `sel_match` high, `sel_in` high and `sel_out` high, four 9-bit write beats taken from `wr_data[8:0]` form one 36-bit word.
- R6: With `sel_order` low at master reset, the first beat of a word is its most significant slice (bits 35:18 for 18-bit slices, 35:27 for 9-bit slices), on both the write and the read side.
- R7: With `sel_order` high at master reset, the first beat of a word is its least significant slice (bits 17:0 or 8:0).
- R8: Changes on `sel_match`, `sel_in`, `sel_out` and `sel_order` while `mrst` is low have no effect on the data paths.
- R9: A pulse on `prst` discards the beats of a partly packed word and keeps the configuration captured at the last master reset.
- R10: `wd_valid` rises only after all slices of a word have been accepted, and a beat offered while `wr_ready` is low is not counted toward any word.
- R11: In 18-bit read mode `rd_data[35:18]` is zero; in 9-bit read mode `rd_data[35:9]` is zero.
- R12: While `mrst` or `prst` is high, `wr_ready` and `rs_ready` are low, and from the next clock edge `wd_valid` and `rd_valid` are low; after `rst_n` releases, both valids are low.
- R13: A word on `wd_data` or a beat on `rd_data` that is offered and not taken stays unchanged, with its valid held high, until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mrst | input | 1 | Master reset, active high: clears data paths and captures the selects |
| prst | input | 1 | Partial reset, active high: clears data paths only |
| sel_match | input | 1 | Bus-match select, captured during master reset |
| sel_in | input | 1 | Write-width select, captured during master reset |
| sel_out | input | 1 | Read-width select, captured during master reset |
| sel_order | input | 1 | Slice order: 0 high slice first, 1 low slice first |
| wr_valid | input | 1 | External write beat is offered |
| wr_ready | output | 1 | Write beat can be accepted |
| wr_data | input | 36 | External write beat, low bits used in narrow modes |
| wd_valid | output | 1 | Full word offered toward storage |
| wd_ready | input | 1 | Storage takes the offered word |
| wd_data | output | 36 | Packed word toward storage |
| rs_valid | input | 1 | Storage offers a word to read |
| rs_ready | output | 1 | Word from storage can be taken |
| rs_data | input | 36 | Word from storage |
| rd_valid | output | 1 | External read beat is offered |
| rd_ready | input | 1 | External reader takes the beat |
| rd_data | output | 36 | External read beat, low bits used in narrow modes |

## Verification
The bench targets slice ordering in both directions and both orders; a design that reversed the position sequence would deliver 9-bit lanes as 3,2,1,0 where 0,1,2,3 is due, or pack them mirrored. It holds a completed word unread and keeps a beat offered while the block stalls, so a counter that stepped on valid alone would shift every later word by one slice. It pulses partial reset between the second and third of four narrow beats, which a design keeping stale beats would merge into the next word, and it checks that the order chosen before that reset still applies. It also changes the selects after every master reset, which catches a latch that follows its pins.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  localparam int LANE_W  = 9;
  localparam int LANES   = 4;
  localparam int WORD_W  = LANE_W * LANES;

  // Slice width as a shift: full word, half word or quarter word per beat
  typedef enum logic [1:0] {
    WC_FULL    = 2'd0,
    WC_HALF    = 2'd1,
    WC_QUARTER = 2'd2
  } wcode_e;

  typedef struct packed {
    wcode_e wr;
    wcode_e rd;
    logic   little;
  } bwa_cfg_t;

  localparam bwa_cfg_t CFG_RESET = '{wr: WC_FULL, rd: WC_FULL, little: 1'b0};

  function automatic bwa_cfg_t decode_cfg(input logic m, input logic i,
                                          input logic o, input logic ord);
    bwa_cfg_t c;
    c.little = ord;
    c.wr     = WC_FULL;
    c.rd     = WC_FULL;
    if (m) begin
      unique case ({i, o})
        2'b00:   begin c.wr = WC_FULL;    c.rd = WC_HALF;    end
        2'b01:   begin c.wr = WC_FULL;    c.rd = WC_QUARTER; end
        2'b10:   begin c.wr = WC_HALF;    c.rd = WC_FULL;    end
        default: begin c.wr = WC_QUARTER; c.rd = WC_FULL;    end
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
  import bwa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mrst,
  input  logic     sel_match,
  input  logic     sel_in,
  input  logic     sel_out,
  input  logic     sel_order,
  output bwa_cfg_t cfg
);

  bwa_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (mrst) cfg_d = decode_cfg(sel_match, sel_in, sel_out, sel_order);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  // R8: selects only matter while master reset is high
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst |=> $stable(cfg_q));

endmodule

// File: rtl/bwa_pack.sv
module bwa_pack
  import bwa_pkg::*;
#(
  parameter int P_LANE_W = bwa_pkg::LANE_W,
  parameter int P_LANES  = bwa_pkg::LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  wcode_e              wlg,
  input  logic                little,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [P_LANE_W*P_LANES-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [P_LANE_W*P_LANES-1:0] out_data
);

  localparam int W  = P_LANE_W * P_LANES;
  localparam int LG = $clog2(P_LANES);
  localparam int CW = (LG < 1) ? 1 : LG;

  logic [CW-1:0] cnt_q, cnt_d, last_idx, pos;
  logic [W-1:0]  acc_q, acc_d, merged, word_q, word_d;
  logic          full_q, full_d;
  logic          accept, drain, last;

  assign last_idx = CW'((1 << int'(wlg)) - 1);
  assign pos      = little ? cnt_q : (last_idx - cnt_q);
  assign last     = (cnt_q == last_idx);
  assign in_ready = !flush && (!full_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign drain    = full_q && out_ready;

  // Each storage lane takes the incoming beat when it belongs to the slice
  // selected by the current position, and keeps its collected value otherwise.
  for (genvar j = 0; j < P_LANES; j++) begin : g_lane
    logic [CW-1:0] slot, src;
    assign slot = CW'(j >> (LG - int'(wlg)));
    assign src  = CW'(j & ((1 << (LG - int'(wlg))) - 1));
    assign merged[j*P_LANE_W +: P_LANE_W] = (slot == pos)
      ? in_data[int'(src)*P_LANE_W +: P_LANE_W]
      : acc_q[j*P_LANE_W +: P_LANE_W];
  end

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    word_d = word_q;
    full_d = full_q && !drain;
    if (accept) begin
      acc_d = merged;
      if (last) begin
        cnt_d  = '0;
        word_d = merged;
        full_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (flush) begin
      cnt_d  = '0;
      acc_d  = '0;
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      word_q <= word_d;
      full_q <= full_d;
    end
  end

  assign out_valid = full_q;
  assign out_data  = word_q;

  // R10: slice position moves only on an accepted beat
  p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !flush) |=> $stable(cnt_q));

  // R10: a word appears only after a beat that closed it
  p_word_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(accept) && ($past(cnt_q) == $past(last_idx)));

  // R13: an offered word is held until storage takes it
  p_hold_word_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready && !flush) |=> full_q && $stable(word_q));

endmodule

// File: rtl/bwa_unpack.sv
module bwa_unpack
  import bwa_pkg::*;
#(
  parameter int P_LANE_W = bwa_pkg::LANE_W,
  parameter int P_LANES  = bwa_pkg::LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  wcode_e              rlg,
  input  logic                little,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [P_LANE_W*P_LANES-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [P_LANE_W*P_LANES-1:0] out_data
);

  localparam int W  = P_LANE_W * P_LANES;
  localparam int LG = $clog2(P_LANES);
  localparam int CW = (LG < 1) ? 1 : LG;

  logic [CW-1:0] cnt_q, cnt_d, last_idx, pos;
  logic [W-1:0]  word_q, word_d;
  logic          has_q, has_d;
  logic          take, load, last;

  assign last_idx = CW'((1 << int'(rlg)) - 1);
  assign pos      = little ? cnt_q : (last_idx - cnt_q);
  assign last     = (cnt_q == last_idx);
  assign take     = has_q && out_ready;
  assign in_ready = !flush && (!has_q || (out_ready && last));
  assign load     = in_valid && in_ready;

  // Output lane j carries lane j of the selected slice; lanes beyond the
  // slice width are driven low.
  for (genvar j = 0; j < P_LANES; j++) begin : g_lane
    logic [CW-1:0] idx;
    logic          used;
    assign used = (j < (P_LANES >> int'(rlg)));
    assign idx  = CW'(int'(pos) * (P_LANES >> int'(rlg)) + j);
    assign out_data[j*P_LANE_W +: P_LANE_W] = used
      ? word_q[int'(idx)*P_LANE_W +: P_LANE_W]
      : '0;
  end

  always_comb begin
    cnt_d  = cnt_q;
    has_d  = has_q;
    word_d = word_q;
    if (take) begin
      if (last) begin
        cnt_d = '0;
        has_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (load) begin
      word_d = in_data;
      has_d  = 1'b1;
    end
    if (flush) begin
      cnt_d = '0;
      has_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      has_q  <= 1'b0;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      has_q  <= has_d;
      word_q <= word_d;
    end
  end

  assign out_valid = has_q;

  // R13: an offered read beat stays put until taken
  p_beat_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (has_q && !out_ready && !flush) |=> has_q && $stable(out_data));

  // R11: upper lanes are quiet in the narrow read modes
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (has_q && rlg == WC_QUARTER) |-> (out_data[W-1:P_LANE_W] == '0));

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              sel_match,
  input  logic              sel_in,
  input  logic              sel_out,
  input  logic              sel_order,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [WORD_W-1:0] wd_data,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [WORD_W-1:0] rs_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);

  logic [1:0] rst_pipe;
  logic       rst_s_n;
  logic       flush;
  bwa_cfg_t   cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];
  assign flush   = mrst || prst;

  bwa_cfg_latch u_cfg (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .mrst      (mrst),
    .sel_match (sel_match),
    .sel_in    (sel_in),
    .sel_out   (sel_out),
    .sel_order (sel_order),
    .cfg       (cfg)
  );

  bwa_pack #(.P_LANE_W(LANE_W), .P_LANES(LANES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .flush     (flush),
    .wlg       (cfg.wr),
    .little    (cfg.little),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_data   (wr_data),
    .out_valid (wd_valid),
    .out_ready (wd_ready),
    .out_data  (wd_data)
  );

  bwa_unpack #(.P_LANE_W(LANE_W), .P_LANES(LANES)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .flush     (flush),
    .rlg       (cfg.rd),
    .little    (cfg.little),
    .in_valid  (rs_valid),
    .in_ready  (rs_ready),
    .in_data   (rs_data),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .out_data  (rd_data)
  );

  // R12: nothing is accepted while either reset is held
  p_flush_quiet_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush |-> (!wr_ready && !rs_ready));

  // R12: both offers are withdrawn after a reset edge
  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    flush |=> (!wd_valid && !rd_valid));

  // R11: half-width reads leave the upper half low
  p_half_zero_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_valid && cfg.rd == WC_HALF) |-> (rd_data[WORD_W-1:WORD_W/2] == '0));

endmodule

// File: tb/sim_bus_width_adapter.sv
`timescale 1ns/1ps
module sim_bus_width_adapter;

  logic        clk = 1'b0;
  logic        rst_n, mrst, prst;
  logic        sel_match, sel_in, sel_out, sel_order;
  logic        wr_valid, wr_ready, wd_valid, wd_ready;
  logic        rs_valid, rs_ready, rd_valid, rd_ready;
  logic [35:0] wr_data, wd_data, rs_data, rd_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_width_adapter u0 (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .prst(prst),
    .sel_match(sel_match), .sel_in(sel_in), .sel_out(sel_out), .sel_order(sel_order),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // All tasks start and end just after a falling edge.
  task automatic configure(input logic m, input logic i, input logic o, input logic ord);
    sel_match = m; sel_in = i; sel_out = o; sel_order = ord; mrst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R12 ready low in reset", {34'd0, wr_ready, rs_ready}, 36'd0);
    chk("R12 valid low in reset", {34'd0, wd_valid, rd_valid}, 36'd0);
    mrst = 1'b0;
    sel_match = ~m; sel_in = ~i; sel_out = ~o; sel_order = ~ord;
    @(negedge clk);
  endtask

  task automatic put(input logic [35:0] d);
    wr_valid = 1'b1; wr_data = d;
    #1;
    while (!wr_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0; wr_data = '1;
  endtask

  task automatic get_word(input string req, input logic [35:0] exp);
    wd_ready = 1'b1;
    #1;
    while (!wd_valid) begin @(negedge clk); #1; end
    chk(req, wd_data, exp);
    @(posedge clk); @(negedge clk);
    wd_ready = 1'b0;
  endtask

  task automatic push_word(input logic [35:0] d);
    rs_valid = 1'b1; rs_data = d;
    #1;
    while (!rs_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic pull_beat(input string req, input logic [35:0] exp);
    rd_ready = 1'b1;
    #1;
    while (!rd_valid) begin @(negedge clk); #1; end
    chk(req, rd_data, exp);
    @(posedge clk); @(negedge clk);
    rd_ready = 1'b0;
  endtask

  // R1 and R8: pins for narrow modes given, but match low wins
  task automatic t_full_pass();
    configure(1'b0, 1'b1, 1'b1, 1'b1);
    put(36'h9_1234_5678);
    get_word("R1 write pass-through", 36'h9_1234_5678);
    push_word(36'hA_BCDE_F012);
    pull_beat("R1 R8 read pass-through", 36'hA_BCDE_F012);
  endtask

  // R2, R6, R11, R13 on the read side
  task automatic t_rd_half_big();
    logic [35:0] w = 36'hC_3A5F_0E71;
    configure(1'b1, 1'b0, 1'b0, 1'b0);
    push_word(w);
    repeat (2) begin
      @(negedge clk);
      chk("R13 read beat held", rd_data, {18'd0, w[35:18]});
    end
    pull_beat("R2 R6 first half is high", {18'd0, w[35:18]});
    pull_beat("R2 R11 second half is low", {18'd0, w[17:0]});
    put(36'h1_2222_3333);
    get_word("R2 write side stays full width", 36'h1_2222_3333);
  endtask

  // R3, R7, R11
  task automatic t_rd_quarter_little();
    logic [35:0] w = 36'h7_1B2C_3D4E;
    configure(1'b1, 1'b0, 1'b1, 1'b1);
    push_word(w);
    for (int k = 0; k < 4; k++)
      pull_beat("R3 R7 R11 quarter beat", {27'd0, w[k*9 +: 9]});
    chk("R3 no extra beat", {35'd0, rd_valid}, 36'd0);
  endtask

  // R4, R6, R13 on the write side
  task automatic t_wr_half_big();
    configure(1'b1, 1'b1, 1'b0, 1'b0);
    put({18'h3FFFF, 18'h2_5A5A});
    put({18'h15555, 18'h1_0F0F});
    repeat (2) begin
      @(negedge clk);
      chk("R13 word held", wd_data, {18'h2_5A5A, 18'h1_0F0F});
    end
    get_word("R4 R6 first beat lands high", {18'h2_5A5A, 18'h1_0F0F});
  endtask

  // R5, R7, R10
  task automatic t_wr_quarter_little();
    logic [8:0] b [4];
    logic [8:0] c [4];
    b = '{9'h011, 9'h122, 9'h033, 9'h1C4};
    c = '{9'h1A5, 9'h0B6, 9'h1C7, 9'h0D8};
    configure(1'b1, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) put({27'h7FFFFFF, b[k]});
    chk("R10 no word after three beats", {35'd0, wd_valid}, 36'd0);
    put({27'd0, b[3]});
    wr_valid = 1'b1; wr_data = {27'd0, 9'h1FF};
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R10 stalled beat refused", {35'd0, wr_ready}, 36'd0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    get_word("R5 R7 first lane is low", {b[3], b[2], b[1], b[0]});
    for (int k = 0; k < 3; k++) put({27'd0, c[k]});
    chk("R10 partial word not offered", {35'd0, wd_valid}, 36'd0);
    put({27'd0, c[3]});
    get_word("R10 stalled beat not counted", {c[3], c[2], c[1], c[0]});
  endtask

  // R9: partial reset drops beats and keeps the order
  task automatic t_partial();
    configure(1'b1, 1'b1, 1'b1, 1'b1);
    put({27'd0, 9'h0AA});
    put({27'd0, 9'h0BB});
    prst = 1'b1;
    @(negedge clk);
    prst = 1'b0;
    for (int k = 0; k < 4; k++) put({27'd0, 9'(9'h101 + k)});
    get_word("R9 fresh word after partial reset", {9'h104, 9'h103, 9'h102, 9'h101});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mrst = 1'b0; prst = 1'b0;
    sel_match = 1'b0; sel_in = 1'b0; sel_out = 1'b0; sel_order = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wd_ready = 1'b0;
    rs_valid = 1'b0; rs_data = '0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 valids low after reset", {34'd0, wd_valid, rd_valid}, 36'd0);
    chk("R12 ready after reset", {34'd0, wr_ready, rs_ready}, 36'd3);
    t_full_pass();
    t_rd_half_big();
    t_rd_quarter_little();
    t_wr_half_big();
    t_wr_quarter_little();
    t_partial();
    summary();
    $finish;
  end

endmodule